// File: doc/BRIEF.md
# DMA Bus Handshake Engine

This block sits between an internal word-wide endpoint FIFO and an external DMA bus. Data moves either from the bus into the device (the FIFO receives words) or from the device onto the bus (the FIFO supplies words). The block raises a request line when the FIFO can take part in a transfer. It recognises or generates the read, write and acknowledge strobes that pace each bus cycle. It also flags the final bus cycle of a transfer on an end-of-transfer line.

In the slave role an external controller drives the strobes and the block decodes them. In the master role the block produces the strobes itself, as fixed-length pulses. A strobe mode picks which pin paces inbound data and which pin paces outbound data, and the same pin can have different meanings in the two roles. Each control line has its own programmable active level. The bus can be 8 or 16 bits wide. On an 8-bit bus two bus cycles carry one FIFO word. An optional byte-lane swap reverses the order of the two bytes.

Top module: `dma_hs_engine`

## Requirements
- R1: `dreq_o` is at its active level exactly when `xfer_en` is 1, the configuration is legal, and the FIFO can take part: `wr_ready` is 1 when `dir`=0 (bus to device), or `rd_valid` is 1 when `dir`=1 (device to bus).
- R2: No word is popped and no master strobe starts while `rd_valid` is 0, so a device-to-bus transfer halts once the FIFO is empty.
- R3: Strobe mode 0 (`cfg_mode`=0). Master role: the read strobe (`dior`) paces inbound data and the write strobe (`diow`) paces outbound data. Slave role: `diow` paces inbound data and `dior` paces outbound data.
- R4: Strobe mode 1. Master role: `dior` paces inbound data and the acknowledge line (`dack`) paces outbound data. Slave role: `dack` paces inbound data and `dior` paces outbound data.
- R5: Strobe mode 2: `dack` alone paces both directions, in both roles.
- R6: Mode 3, or mode 2 with `cfg_wide`=0, is illegal. In that case `err_o`=1, every strobe output and `dreq_o` stay at their inactive levels, and no data moves.
- R7: `cfg_hw` layout, bit 7 down to 0: bits [7:6] lane swap (any non-zero value enables it), [5] EOT level, [4] master role, [3] `dack` level, [2] `dreq` level, [1] `diow` level, [0] `dior` level. A level bit of 1 means active-high and 0 means active-low. `cfg_wide`=1 selects a 16-bit bus and 0 an 8-bit bus.
- R8: In the master role each strobe pulse is active for at least STRB_CYC (default 2) clocks and is followed by at least one inactive clock. Inbound bus data is captured on the clock where the strobe deasserts.
- R9: `bus_oe` is 1 only while an outbound strobe is active.
- R10: On an 8-bit bus the low byte of a word travels first and the high byte second; with the swap enabled the high byte goes first. On a 16-bit bus the swap exchanges the two bytes. Bytes on an 8-bit bus use `bus_dout[7:0]`/`bus_din[7:0]`, and `bus_dout[15:8]` is 0.
- R11: `eot_o` is at its active level only during the strobe that moves the last byte of a word flagged by `rd_last`.
- R12: In the slave role a word or byte is taken on the deasserting edge of the selected inbound strobe. Activity on any pin the mode does not select has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw | input | 8 | Level, role and swap configuration byte |
| cfg_mode | input | 2 | Strobe mode |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| dir | input | 1 | 0: bus to device, 1: device to bus |
| xfer_en | input | 1 | Transfer enable; 0 also rewinds the byte position |
| rd_data | input | 16 | FIFO head word |
| rd_valid | input | 1 | FIFO holds a word |
| rd_last | input | 1 | Head word is the final one |
| rd_ready | output | 1 | Pop the head word |
| wr_data | output | 16 | Word for the FIFO |
| wr_valid | output | 1 | Push `wr_data` |
| wr_ready | input | 1 | FIFO has room |
| dreq_o | output | 1 | Request line |
| dior_i | input | 1 | Read strobe pin, slave role |
| diow_i | input | 1 | Write strobe pin, slave role |
| dack_i | input | 1 | Acknowledge pin, slave role |
| dior_o | output | 1 | Read strobe pin, master role |
| diow_o | output | 1 | Write strobe pin, master role |
| dack_o | output | 1 | Acknowledge pin, master role |
| strb_oe | output | 1 | Strobe pins driven (master role) |
| eot_o | output | 1 | End-of-transfer line |
| bus_din | input | 16 | Bus data in |
| bus_dout | output | 16 | Bus data out |
| bus_oe | output | 1 | Bus data output enable |
| err_o | output | 1 | Illegal configuration |

## Verification
A table of configurations runs three-word transfers through every strobe mode in both roles and both directions, with mixed active levels, on 8-bit and 16-bit buses, with and without the lane swap. A wrong pin choice, an inverted level or a reversed byte order each gives a distinct mismatch in the collected bus items or FIFO words. Directed cases drive the request line against FIFO room and data, hold an empty FIFO under a master, pulse unselected pins in the slave role, and apply both illegal settings.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [1:0] {PIN_RD, PIN_WR, PIN_ACK, PIN_NONE} pin_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_GAP} mst_e;

  typedef struct packed {
    logic [1:0] swap;
    logic       eot_pol;
    logic       master;
    logic       ack_pol;
    logic       req_pol;
    logic       wr_pol;
    logic       rd_pol;
  } hw_cfg_t;

  // pin that paces bus-to-device data
  function automatic pin_e in_pin_of(input logic [1:0] mode, input logic master);
    case (mode)
      2'd0:    return master ? PIN_RD : PIN_WR;
      2'd1:    return master ? PIN_RD : PIN_ACK;
      2'd2:    return PIN_ACK;
      default: return PIN_NONE;
    endcase
  endfunction

  // pin that paces device-to-bus data
  function automatic pin_e out_pin_of(input logic [1:0] mode, input logic master);
    case (mode)
      2'd0:    return master ? PIN_WR : PIN_RD;
      2'd1:    return master ? PIN_ACK : PIN_RD;
      2'd2:    return PIN_ACK;
      default: return PIN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_hs_strobe.sv
module dma_hs_strobe import dma_hs_pkg::*; #(
  parameter int STRB_CYC = 2,
  parameter int BUS_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             go,
  input  logic             sel_act,
  input  logic [BUS_W-1:0] bus_din,
  output logic             s_act,
  output logic             ev,
  output logic [BUS_W-1:0] cap_data
);

  localparam int CW = (STRB_CYC > 2) ? $clog2(STRB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STRB_CYC - 1);

  mst_e             st, st_n;
  logic [CW-1:0]    cnt, cnt_n;
  logic             stb_q, stb_n;
  logic [BUS_W-1:0] din_lat, din_n;
  logic             m_stb;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_IDLE: if (go) begin
        st_n  = ST_ACT;
        cnt_n = '0;
      end
      ST_ACT: if (cnt == LAST) st_n = ST_GAP;
              else cnt_n = cnt + 1'b1;
      default: st_n = ST_IDLE;
    endcase
    if (!master) st_n = ST_IDLE;
    stb_n = !master && sel_act;
    din_n = sel_act ? bus_din : din_lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      stb_q   <= 1'b0;
      din_lat <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      stb_q   <= stb_n;
      din_lat <= din_n;
    end
  end

  assign m_stb    = (st == ST_ACT);
  assign s_act    = master ? m_stb : sel_act;
  assign ev       = master ? (m_stb && cnt == LAST) : (stb_q && !sel_act);
  assign cap_data = master ? bus_din : din_lat;

  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_stb) |=> m_stb); // R8
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_stb) |=> !m_stb); // R8

endmodule

// File: rtl/dma_hs_lanes.sv
module dma_hs_lanes #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wide,
  input  logic             swap,
  input  logic             dir,
  input  logic             ev,
  input  logic [BUS_W-1:0] cap_data,
  input  logic [BUS_W-1:0] rd_data,
  input  logic             rd_valid,
  output logic [BUS_W-1:0] bus_dout,
  output logic             last_byte,
  output logic             rd_ready,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid
);

  localparam int BYTE_W = BUS_W / 2;

  logic              bsel, bsel_n;
  logic [BYTE_W-1:0] hold, hold_n;
  logic              wv_q, wv_n;
  logic [BUS_W-1:0]  wd_q, wd_n, word_in;
  logic              push;

  always_comb begin
    last_byte = wide | bsel;
    bsel_n    = bsel;
    if (clr) bsel_n = 1'b0;
    else if (ev && !wide) bsel_n = ~bsel;
    hold_n = hold;
    if (ev && !wide && !bsel) hold_n = cap_data[BYTE_W-1:0];
    if (wide)
      word_in = swap ? {cap_data[BYTE_W-1:0], cap_data[BUS_W-1:BYTE_W]} : cap_data;
    else
      word_in = swap ? {hold, cap_data[BYTE_W-1:0]} : {cap_data[BYTE_W-1:0], hold};
    push = ev && !dir && last_byte && !clr;
    wv_n = push;
    wd_n = push ? word_in : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsel <= 1'b0;
      hold <= '0;
      wv_q <= 1'b0;
      wd_q <= '0;
    end else begin
      bsel <= bsel_n;
      hold <= hold_n;
      wv_q <= wv_n;
      wd_q <= wd_n;
    end
  end

  always_comb begin
    if (wide)
      bus_dout = swap ? {rd_data[BYTE_W-1:0], rd_data[BUS_W-1:BYTE_W]} : rd_data;
    else
      bus_dout = {{BYTE_W{1'b0}},
                  (bsel ^ swap) ? rd_data[BUS_W-1:BYTE_W] : rd_data[BYTE_W-1:0]};
  end

  assign rd_ready = ev && dir && last_byte && rd_valid && !clr;
  assign wr_valid = wv_q;
  assign wr_data  = wd_q;

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_valid); // R2

endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine import dma_hs_pkg::*; #(
  parameter int STRB_CYC = 2,
  parameter int BUS_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_hw,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_wide,
  input  logic             dir,
  input  logic             xfer_en,
  input  logic [BUS_W-1:0] rd_data,
  input  logic             rd_valid,
  input  logic             rd_last,
  output logic             rd_ready,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             dreq_o,
  input  logic             dior_i,
  input  logic             diow_i,
  input  logic             dack_i,
  output logic             dior_o,
  output logic             diow_o,
  output logic             dack_o,
  output logic             strb_oe,
  output logic             eot_o,
  input  logic [BUS_W-1:0] bus_din,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  output logic             err_o
);

  hw_cfg_t          cfg;
  pin_e             sel_pin;
  logic             bad_cfg, req_act, pin_hit, sel_act, go;
  logic             s_act, ev, last_byte, drive_act, eot_act;
  logic [BUS_W-1:0] cap_data;

  assign cfg     = hw_cfg_t'(cfg_hw);
  assign bad_cfg = (cfg_mode == 2'd3) || (cfg_mode == 2'd2 && !cfg_wide);
  assign sel_pin = dir ? out_pin_of(cfg_mode, cfg.master) : in_pin_of(cfg_mode, cfg.master);
  assign req_act = xfer_en && !bad_cfg && (dir ? rd_valid : wr_ready);

  always_comb begin
    case (sel_pin)
      PIN_RD:  pin_hit = (dior_i == cfg.rd_pol);
      PIN_WR:  pin_hit = (diow_i == cfg.wr_pol);
      PIN_ACK: pin_hit = (dack_i == cfg.ack_pol);
      default: pin_hit = 1'b0;
    endcase
  end

  assign sel_act = !cfg.master && xfer_en && !bad_cfg && pin_hit;
  assign go      = cfg.master && req_act;

  dma_hs_strobe #(.STRB_CYC(STRB_CYC), .BUS_W(BUS_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .master(cfg.master), .go(go), .sel_act(sel_act),
    .bus_din(bus_din), .s_act(s_act), .ev(ev), .cap_data(cap_data)
  );

  dma_hs_lanes #(.BUS_W(BUS_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .clr(!xfer_en), .wide(cfg_wide), .swap(|cfg.swap),
    .dir(dir), .ev(ev), .cap_data(cap_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .bus_dout(bus_dout), .last_byte(last_byte), .rd_ready(rd_ready),
    .wr_data(wr_data), .wr_valid(wr_valid)
  );

  assign drive_act = cfg.master && s_act;
  assign dior_o    = (drive_act && sel_pin == PIN_RD)  ? cfg.rd_pol  : ~cfg.rd_pol;
  assign diow_o    = (drive_act && sel_pin == PIN_WR)  ? cfg.wr_pol  : ~cfg.wr_pol;
  assign dack_o    = (drive_act && sel_pin == PIN_ACK) ? cfg.ack_pol : ~cfg.ack_pol;
  assign strb_oe   = cfg.master;
  assign dreq_o    = req_act ? cfg.req_pol : ~cfg.req_pol;
  assign eot_act   = s_act && dir && rd_valid && rd_last && last_byte;
  assign eot_o     = eot_act ? cfg.eot_pol : ~cfg.eot_pol;
  assign bus_oe    = s_act && dir;
  assign err_o     = bad_cfg;

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (dreq_o == ~cfg.req_pol) && !bus_oe && !wr_valid); // R6
  AST_OE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && cfg.master) |->
      ((dior_o == cfg.rd_pol) || (diow_o == cfg.wr_pol) || (dack_o == cfg.ack_pol))); // R9
  AST_EOT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_o == cfg.eot_pol) |-> bus_oe); // R11
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ((dreq_o == cfg.req_pol) && dir) |-> rd_valid); // R1

endmodule

// File: tb/sim_dma_hs_engine.sv
module sim_dma_hs_engine;

  localparam int STRB = 2;
  localparam int NV   = 12;
  localparam int WDOG = 150000;

  // {data base[31:16], dir, master, wide, mode[1:0], swap, levels{eot,ack,req,wr,rd}, 5'd0}
  localparam logic [31:0] VEC [NV] = '{
    {16'h1234, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 5'b00100, 5'd0},
    {16'hA1B2, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 5'b00100, 5'd0},
    {16'h3C4D, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 5'b11111, 5'd0},
    {16'h5E6F, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 5'b00000, 5'd0},
    {16'h7081, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 5'b10101, 5'd0},
    {16'h92A3, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 5'b01010, 5'd0},
    {16'hB4C5, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'b00100, 5'd0},
    {16'hD6E7, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 5'b00111, 5'd0},
    {16'hF809, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 5'b11000, 5'd0},
    {16'h1A2B, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 5'b00100, 5'd0},
    {16'h3C5D, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 5'b01111, 5'd0},
    {16'h6E7F, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 5'b00000, 5'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_hw = 8'h04;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_wide = 1'b1;
  logic        dir = 1'b0;
  logic        xfer_en = 1'b0;
  logic [15:0] rd_data = 16'h0;
  logic        rd_valid = 1'b0, rd_last = 1'b0;
  logic        rd_ready;
  logic [15:0] wr_data;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic        dreq_o;
  logic        dior_i = 1'b1, diow_i = 1'b1, dack_i = 1'b1;
  logic        dior_o, diow_o, dack_o, strb_oe, eot_o;
  logic [15:0] bus_din = 16'h0;
  logic [15:0] bus_dout;
  logic        bus_oe, err_o;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] fifo_q[$];
  logic [15:0] cap_q[$];
  logic        pop_f = 1'b0, push_f = 1'b0;
  logic [15:0] push_d = 16'h0;

  always #5 clk = ~clk;

  dma_hs_engine #(.STRB_CYC(STRB), .BUS_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hw(cfg_hw), .cfg_mode(cfg_mode), .cfg_wide(cfg_wide),
    .dir(dir), .xfer_en(xfer_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
    .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .dreq_o(dreq_o), .dior_i(dior_i), .diow_i(diow_i), .dack_i(dack_i),
    .dior_o(dior_o), .diow_o(diow_o), .dack_o(dack_o), .strb_oe(strb_oe), .eot_o(eot_o),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .err_o(err_o)
  );

  always @(posedge clk) begin
    pop_f  <= rd_ready && rd_valid;
    push_f <= wr_valid;
    push_d <= wr_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    rd_valid = (fifo_q.size() > 0);
    rd_data  = rd_valid ? fifo_q[0] : 16'h0;
    rd_last  = (fifo_q.size() == 1);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (pop_f && fifo_q.size() > 0) void'(fifo_q.pop_front());
    if (push_f) cap_q.push_back(push_d);
    refresh();
    if (cyc > WDOG) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // 0 read strobe, 1 write strobe, 2 acknowledge (R3, R4, R5)
  function automatic int in_pin(input logic [1:0] m, input logic ms);
    if (m == 2'd0) return ms ? 0 : 1;
    if (m == 2'd1) return ms ? 0 : 2;
    return 2;
  endfunction
  function automatic int out_pin(input logic [1:0] m, input logic ms);
    if (m == 2'd0) return ms ? 1 : 0;
    if (m == 2'd1) return ms ? 2 : 0;
    return 2;
  endfunction

  function automatic bit m_active(input int p);
    if (p == 0) return dior_o == cfg_hw[0];
    if (p == 1) return diow_o == cfg_hw[1];
    return dack_o == cfg_hw[3];
  endfunction

  function automatic bit any_m_active();
    return (dior_o == cfg_hw[0]) || (diow_o == cfg_hw[1]) || (dack_o == cfg_hw[3]);
  endfunction

  task automatic set_spin(input int p, input bit act);
    dior_i = (p == 0 && act) ? cfg_hw[0] : ~cfg_hw[0];
    diow_i = (p == 1 && act) ? cfg_hw[1] : ~cfg_hw[1];
    dack_i = (p == 2 && act) ? cfg_hw[3] : ~cfg_hw[3];
  endtask

  task automatic setup(input logic d, input logic ms, input logic wd, input logic [1:0] md,
                       input logic sw, input logic [4:0] pl);
    tick();
    xfer_en  = 1'b0;
    dir      = d;
    cfg_mode = md;
    cfg_wide = wd;
    cfg_hw   = {sw ? 2'b01 : 2'b00, pl[4], ms, pl[3:0]};
    set_spin(3, 1'b0);
    bus_din  = 16'h0;
    tick();
    tick();
    fifo_q.delete();
    cap_q.delete();
    refresh();
  endtask

  task automatic run_case(input logic [31:0] v, input int idx);
    logic [15:0] base;
    logic        d, ms, wd, sw;
    logic [1:0]  md;
    logic [15:0] items[6];
    logic [15:0] expw[3];
    logic [15:0] got[$];
    bit          eotg[$];
    int          nit, p, cnt, guard, plen;
    bit          prev, a, oe_bad, eot_cur, short_p;
    logic [15:0] last;
    string       tg;
    base = v[31:16]; d = v[15]; ms = v[14]; wd = v[13]; md = v[12:11]; sw = v[10];
    setup(d, ms, wd, md, sw, v[9:5]);
    tg  = (md == 2'd0) ? "R3" : (md == 2'd1) ? "R4" : "R5";
    nit = wd ? 3 : 6;
    p   = d ? out_pin(md, ms) : in_pin(md, ms);
    got.delete();
    eotg.delete();
    for (int k = 0; k < 3; k++) begin
      logic [15:0] w;
      w = base + 16'(k) * 16'h2345;
      if (d) begin
        fifo_q.push_back(w);
        if (wd) items[k] = sw ? {w[7:0], w[15:8]} : w;
        else begin
          items[2*k]   = {8'h00, sw ? w[15:8] : w[7:0]};
          items[2*k+1] = {8'h00, sw ? w[7:0] : w[15:8]};
        end
      end else if (wd) begin
        items[k] = w;
        expw[k]  = sw ? {w[7:0], w[15:8]} : w;
      end
    end
    if (!d && !wd) begin
      for (int j = 0; j < 6; j++) items[j] = {8'hA5, base[7:0] + 8'(j) * 8'h1D};
      for (int m = 0; m < 3; m++)
        expw[m] = sw ? {items[2*m][7:0], items[2*m+1][7:0]} : {items[2*m+1][7:0], items[2*m][7:0]};
    end
    refresh();
    oe_bad = 1'b0; eot_cur = 1'b0; short_p = 1'b0;
    if (ms) begin
      bus_din = items[0];
      xfer_en = 1'b1;
      prev = 1'b0; cnt = 0; guard = 0; plen = 0; last = 16'h0;
      while (cnt < nit && guard < 400) begin
        tick();
        guard++;
        a = m_active(p);
        if (a) begin
          plen++;
          last = bus_dout;
          if (bus_oe !== d) oe_bad = 1'b1;
          if (eot_o == cfg_hw[5]) eot_cur = 1'b1;
        end else if (prev) begin
          got.push_back(last);
          eotg.push_back(eot_cur);
          if (plen < STRB) short_p = 1'b1;
          eot_cur = 1'b0; plen = 0; cnt++;
          if (!d && cnt < nit) bus_din = items[cnt];
          if (cnt == nit) xfer_en = 1'b0;
        end
        prev = a;
      end
      chk(cnt == nit, $sformatf("%s case %0d strobe count", tg, idx), cnt, nit);
      chk(!short_p, $sformatf("R8 case %0d pulse length", idx), short_p, 0);
      xfer_en = 1'b0;
    end else begin
      xfer_en = 1'b1;
      tick();
      for (int k = 0; k < nit; k++) begin
        if (!d) bus_din = items[k];
        set_spin(p, 1'b1);
        tick();
        tick();
        if (d) begin
          got.push_back(bus_dout);
          eotg.push_back(eot_o == cfg_hw[5]);
          if (bus_oe !== 1'b1) oe_bad = 1'b1;
        end else if (bus_oe !== 1'b0) oe_bad = 1'b1;
        set_spin(p, 1'b0);
        tick();
        tick();
        tick();
      end
      xfer_en = 1'b0;
    end
    for (int k = 0; k < 4; k++) tick();
    chk(!oe_bad, $sformatf("R9 case %0d output enable", idx), oe_bad, 0);
    if (d) begin
      chk(got.size() == nit, $sformatf("%s case %0d items", tg, idx), got.size(), nit);
      for (int k = 0; k < nit && k < got.size(); k++) begin
        chk(got[k] == items[k], $sformatf("%s/R10 case %0d item %0d", tg, idx, k), got[k], items[k]);
        chk(eotg[k] == (k == nit - 1), $sformatf("R11 case %0d item %0d", idx, k), eotg[k], k == nit - 1);
      end
      chk(fifo_q.size() == 0, $sformatf("R2 case %0d fifo drained", idx), fifo_q.size(), 0);
    end else begin
      chk(cap_q.size() == 3, $sformatf("%s/R12 case %0d words", tg, idx), cap_q.size(), 3);
      for (int m = 0; m < 3 && m < cap_q.size(); m++)
        chk(cap_q[m] == expw[m], $sformatf("%s/R10 case %0d word %0d", tg, idx, m), cap_q[m], expw[m]);
    end
  endtask

  initial begin
    bit seen;
    tick();
    // reset state, master role, levels 0x04 -> dreq active-high, strobes active-low
    cfg_hw = 8'h14;
    tick();
    chk(!wr_valid && !rd_ready && !bus_oe, "R9 reset outputs", {wr_valid, rd_ready, bus_oe}, 0);
    chk(dior_o && diow_o && dack_o, "R7 reset strobes inactive", {dior_o, diow_o, dack_o}, 3'b111);
    chk(dreq_o == 1'b0, "R1 reset request idle", dreq_o, 0);
    rst_n = 1'b1;
    tick();

    foreach (VEC[i]) run_case(VEC[i], i);

    // R1: request follows room / data and its level bit
    setup(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'b00100);
    wr_ready = 1'b0; xfer_en = 1'b1; tick();
    chk(dreq_o == 1'b0, "R1 no room", dreq_o, 0);
    wr_ready = 1'b1; tick();
    chk(dreq_o == 1'b1, "R1 room", dreq_o, 1);
    xfer_en = 1'b0; tick();
    chk(dreq_o == 1'b0, "R1 disabled", dreq_o, 0);
    setup(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 5'b00000);
    xfer_en = 1'b1; tick();
    chk(dreq_o == 1'b1, "R1 empty, active-low level", dreq_o, 1);
    fifo_q.push_back(16'hCAFE); refresh(); tick();
    chk(dreq_o == 1'b0, "R1 data, active-low level", dreq_o, 0);
    xfer_en = 1'b0; tick();

    // R2: master with an empty FIFO never strobes
    setup(1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 5'b00100);
    xfer_en = 1'b1; seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (any_m_active() || bus_oe) seen = 1'b1;
    end
    chk(!seen, "R2 empty fifo holds master", seen, 0);
    xfer_en = 1'b0; tick();

    // R12: unselected pins ignored in slave mode 0 inbound (only diow selected)
    setup(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'b00100);
    xfer_en = 1'b1; bus_din = 16'h5A5A;
    for (int k = 0; k < 4; k++) begin
      set_spin(0, 1'b1); tick(); tick();
      set_spin(2, 1'b1); tick(); tick();
      set_spin(0, 1'b0); tick(); tick();
    end
    for (int k = 0; k < 4; k++) tick();
    chk(cap_q.size() == 0, "R12 unselected pins ignored", cap_q.size(), 0);
    xfer_en = 1'b0; tick();

    // R6: illegal settings with data available
    for (int t = 0; t < 2; t++) begin
      setup(1'b1, 1'b1, t == 0 ? 1'b0 : 1'b1, t == 0 ? 2'd2 : 2'd3, 1'b0, 5'b00100);
      fifo_q.push_back(16'hBEEF); refresh();
      xfer_en = 1'b1; seen = 1'b0;
      for (int k = 0; k < 12; k++) begin
        tick();
        if (any_m_active() || bus_oe) seen = 1'b1;
      end
      chk(err_o == 1'b1, $sformatf("R6 illegal %0d flag", t), err_o, 1);
      chk(dreq_o == 1'b0, $sformatf("R6 illegal %0d request", t), dreq_o, 0);
      chk(!seen, $sformatf("R6 illegal %0d strobes", t), seen, 0);
      chk(fifo_q.size() == 1, $sformatf("R6 illegal %0d fifo untouched", t), fifo_q.size(), 1);
      xfer_en = 1'b0; tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule